// File: doc/BRIEF.md
# Stack Pointer Unit with Interrupt Lockout

This block keeps the stack pointer of a small processor core. The pointer is one register of `ADDR_W` bits, seen by software as two byte registers (low and high) on a simple I/O read/write port. The stack grows toward lower addresses. A single-byte push stores at the current pointer and then moves it down by one. A single-byte pop first moves the pointer up by one and then reads at the new value. A call or interrupt entry stores a return address of several bytes, and a return or interrupt return takes it back. The block walks through those bytes one per clock. It gives one memory byte address per cycle and raises `busy_o` while more bytes are still to come.

The size of the return address is set when the design is built. It follows from the program memory size parameter: 2 bytes up to 128 KB, 3 bytes above that. Changing the pointer from software takes two byte writes, and an interrupt must not land between them. So a write to the low byte raises an interrupt mask for a bounded window. The window ends after a fixed number of retired instructions, or at the next I/O write, whichever comes first. The SRAM, the instruction decoder and the interrupt controller sit outside this block. Its outputs are addresses, a busy flag and the mask.

Top module: `sp_unit`

## Requirements
- R1: During and after reset, `sp_o` equals `SRAM_TOP` (default 16'h5FFF), and `irq_mask_o`, `busy_o` and `mem_valid_o` are 0.
- R2: A `push_i` pulse while idle makes `sp_o` one lower one cycle later. In that same cycle `mem_valid_o` is 1 and `mem_addr_o` holds the old pointer.
- R3: A `pop_i` pulse while idle makes `sp_o` one higher one cycle later. In that same cycle `mem_valid_o` is 1 and `mem_addr_o` holds the new pointer.
- R4: A `call_i` pulse while idle gives one byte per cycle on the next RA cycles, where RA is the return-address size. The byte addresses are the pointer, then the pointer minus 1, and so on. The pointer ends RA lower. `busy_o` is 1 in every cycle after the pulse until the last byte is shown.
- R5: A `ret_i` pulse while idle gives RA bytes, one per cycle. In each of them the pointer goes up by one and `mem_addr_o` equals the new pointer. `busy_o` behaves as in R4.
- R6: RA is 2 when `PROG_KB` is 128 or less and 3 when it is larger. The default of 192 gives RA = 3.
- R7: A write with `io_we_i` replaces the low byte (`io_hi_i`=0) or the high byte (`io_hi_i`=1) of the pointer on the next cycle. If a pointer step happens in the same cycle, the step wins and the write data is dropped.
- R8: With `io_re_i`, `io_rdata_o` shows on the next cycle the selected byte of the pointer as it stands after that cycle's step or write.
- R9: A low-byte write sets `irq_mask_o` on the next cycle. It stays set until `LOCK_INSNS` (default 4) `retire_i` pulses have come after the write, and it clears after the last of them.
- R10: While the mask is set, a high-byte write or an `io_wr_other_i` pulse clears it on the next cycle.
- R11: A low-byte write while the mask is set restarts the full `LOCK_INSNS` count.
- R12: A high-byte write never sets `irq_mask_o`.
- R13: Push, pop, call and return pulses that come while `busy_o` is 1 have no effect on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_we_i | input | 1 | Write to a pointer byte register |
| io_re_i | input | 1 | Read of a pointer byte register |
| io_hi_i | input | 1 | Byte select: 0 low byte, 1 high byte |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, registered |
| push_i | input | 1 | Single-byte push pulse |
| pop_i | input | 1 | Single-byte pop pulse |
| call_i | input | 1 | Call or interrupt entry pulse |
| ret_i | input | 1 | Return or interrupt return pulse |
| retire_i | input | 1 | One pulse per retired instruction |
| io_wr_other_i | input | 1 | An I/O write to any other register |
| irq_mask_o | output | 1 | Interrupts masked |
| busy_o | output | 1 | More return-address bytes are still to come |
| mem_valid_o | output | 1 | `mem_addr_o` holds a stack byte address this cycle |
| mem_addr_o | output | ADDR_W | Stack byte address |
| sp_o | output | ADDR_W | Current pointer |

## Verification
The assertions assume that at most one of push, pop, call and return pulses in any cycle. The lockout assertions assume that `retire_i`, `io_wr_other_i` and the I/O strobes arrive as single-cycle levels sampled at the clock. The stimulus meets this by drawing at most one stack pulse per cycle, while it still places pulses inside busy windows and next to software writes. A behavioural model in the bench tracks the pointer, the remaining return-address bytes and the lockout count cycle by cycle. Directed sequences cover the collision and restart cases.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } sp_dir_e;

  // Return-address bytes derived from program memory size in KB
  function automatic int ret_addr_bytes(input int prog_kb);
    return (prog_kb > 128) ? 3 : 2;
  endfunction

endpackage

// File: rtl/sp_seq.sv
module sp_seq
  import sp_pkg::*;
#(
  parameter int RA_BYTES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  logic pop_i,
  input  logic call_i,
  input  logic ret_i,
  output logic step_dn_o,
  output logic step_up_o,
  output logic busy_o
);

  localparam int CW = $clog2(RA_BYTES) + 1;
  localparam logic [CW-1:0] REMAIN = CW'(RA_BYTES - 1);

  logic [CW-1:0] cnt_q;
  sp_dir_e       dir_q;
  logic          active;

  assign active = (cnt_q != '0);
  assign busy_o = active;

  always_comb begin
    if (active) begin
      step_dn_o = (dir_q == DIR_DN);
      step_up_o = (dir_q == DIR_UP);
    end else begin
      step_dn_o = push_i | call_i;
      step_up_o = pop_i | ret_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_DN;
    end else if (active) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (call_i) begin
      cnt_q <= REMAIN;
      dir_q <= DIR_DN;
    end else if (ret_i) begin
      cnt_q <= REMAIN;
      dir_q <= DIR_UP;
    end
  end

  assert_dir_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(dir_q));

  assert_busy_steps_R4: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (step_dn_o ^ step_up_o));

endmodule

// File: rtl/sp_ptr.sv
module sp_ptr #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VAL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_dn_i,
  input  logic              step_up_i,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  input  logic              rd_hi_i,
  output logic [7:0]        rd_data_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_valid_o
);

  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] sp_nxt;
  logic [7:0]        rd_nxt;

  always_comb begin
    sp_nxt = sp_q;
    if (step_dn_i)      sp_nxt = sp_q - 1'b1;
    else if (step_up_i) sp_nxt = sp_q + 1'b1;
    else if (wr_en_i) begin
      if (wr_hi_i) sp_nxt = {wr_data_i[HI_W-1:0], sp_q[7:0]};
      else         sp_nxt = {sp_q[ADDR_W-1:8], wr_data_i};
    end
  end

  assign rd_nxt = rd_hi_i ? 8'(sp_nxt[ADDR_W-1:8]) : sp_nxt[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q        <= RESET_VAL;
      mem_addr_o  <= '0;
      mem_valid_o <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      sp_q        <= sp_nxt;
      mem_valid_o <= step_dn_i | step_up_i;
      if (step_dn_i)      mem_addr_o <= sp_q;
      else if (step_up_i) mem_addr_o <= sp_nxt;
      if (rd_en_i)        rd_data_o  <= rd_nxt;
    end
  end

  assign sp_o = sp_q;

  assert_push_addr_R2: assert property (@(posedge clk) disable iff (rst)
    step_dn_i |=> (mem_valid_o && mem_addr_o == sp_o + 1'b1));

  assert_pop_addr_R3: assert property (@(posedge clk) disable iff (rst)
    step_up_i |=> (mem_valid_o && mem_addr_o == sp_o));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_dn_i && !step_up_i && !wr_en_i) |=> ($stable(sp_o) && !mem_valid_o));

endmodule

// File: rtl/sp_lock.sv
module sp_lock #(
  parameter int LOCK_INSNS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic low_wr_i,
  input  logic other_wr_i,
  input  logic retire_i,
  output logic mask_o
);

  localparam int CW = $clog2(LOCK_INSNS + 1);
  localparam logic [CW-1:0] FULL = CW'(LOCK_INSNS);

  logic [CW-1:0] left_q;
  logic          mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      mask_q <= 1'b0;
    end else if (low_wr_i) begin
      left_q <= FULL;
      mask_q <= 1'b1;
    end else if (mask_q) begin
      if (other_wr_i) begin
        left_q <= '0;
        mask_q <= 1'b0;
      end else if (retire_i) begin
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) mask_q <= 1'b0;
      end
    end
  end

  assign mask_o = mask_q;

  assert_lock_start_R9: assert property (@(posedge clk) disable iff (rst)
    low_wr_i |=> mask_o);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mask_o && !low_wr_i && !other_wr_i && !retire_i) |=> mask_o);

  assert_lock_io_end_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_o && !low_wr_i && other_wr_i) |=> !mask_o);

  assert_lock_bound_R11: assert property (@(posedge clk) disable iff (rst)
    mask_o |-> (left_q != '0 && left_q <= FULL));

endmodule

// File: rtl/sp_unit.sv
module sp_unit
  import sp_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] SRAM_TOP   = 16'h5FFF,
  parameter int                PROG_KB    = 192,
  parameter int                LOCK_INSNS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_we_i,
  input  logic              io_re_i,
  input  logic              io_hi_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              retire_i,
  input  logic              io_wr_other_i,
  output logic              irq_mask_o,
  output logic              busy_o,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] sp_o
);

  localparam int RA_BYTES = ret_addr_bytes(PROG_KB);

  logic step_dn, step_up;
  logic low_wr, other_wr;

  assign low_wr   = io_we_i & ~io_hi_i;
  assign other_wr = (io_we_i & io_hi_i) | io_wr_other_i;

  sp_seq #(.RA_BYTES(RA_BYTES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .step_dn_o (step_dn),
    .step_up_o (step_up),
    .busy_o    (busy_o)
  );

  sp_ptr #(.ADDR_W(ADDR_W), .RESET_VAL(SRAM_TOP)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .step_dn_i   (step_dn),
    .step_up_i   (step_up),
    .wr_en_i     (io_we_i),
    .wr_hi_i     (io_hi_i),
    .wr_data_i   (io_wdata_i),
    .rd_en_i     (io_re_i),
    .rd_hi_i     (io_hi_i),
    .rd_data_o   (io_rdata_o),
    .sp_o        (sp_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_o (mem_valid_o)
  );

  sp_lock #(.LOCK_INSNS(LOCK_INSNS)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .low_wr_i   (low_wr),
    .other_wr_i (other_wr),
    .retire_i   (retire_i),
    .mask_o     (irq_mask_o)
  );

  assert_strobes_onehot_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_i, pop_i, call_i, ret_i}));

  assert_busy_ignores_R13: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && !rst) |-> mem_valid_o);

  assert_hi_no_lock_R12: assert property (@(posedge clk) disable iff (rst)
    (io_we_i && io_hi_i && !irq_mask_o) |=> !irq_mask_o);

  assert_push_moves_R2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !busy_o) |=> (sp_o == $past(sp_o) - 1'b1));

  assert_pop_moves_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !busy_o) |=> (sp_o == $past(sp_o) + 1'b1));

endmodule

// File: tb/sim_sp_unit.sv
module sim_sp_unit;

  localparam int          PROG_KB = 192;
  localparam int          LOCKN   = 4;
  localparam logic [15:0] TOP     = 16'h5FFF;
  localparam int          RA      = (PROG_KB > 128) ? 3 : 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_we = 0, io_re = 0, io_hi = 0;
  logic [7:0] io_wdata = 0;
  logic push = 0, pop = 0, call = 0, ret = 0, retire = 0, io_oth = 0;
  logic [7:0]  io_rdata;
  logic        irq_mask, busy, mem_valid;
  logic [15:0] mem_addr, sp;

  always #4 clk = ~clk;

  sp_unit u0 (
    .clk(clk), .rst(rst), .io_we_i(io_we), .io_re_i(io_re), .io_hi_i(io_hi),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .push_i(push), .pop_i(pop),
    .call_i(call), .ret_i(ret), .retire_i(retire), .io_wr_other_i(io_oth),
    .irq_mask_o(irq_mask), .busy_o(busy), .mem_valid_o(mem_valid),
    .mem_addr_o(mem_addr), .sp_o(sp)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [15:0] m_sp, m_addr;
  logic [7:0]  m_rd;
  bit          m_mask, m_valid, m_dn;
  int          m_rem, m_left;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [15:0] nsp;
    bit upd;
    if (rst) begin
      m_sp = TOP; m_mask = 0; m_left = 0; m_rem = 0; m_valid = 0; m_addr = 0; m_rd = 0;
      return;
    end
    nsp = m_sp; upd = 0;
    if (m_rem > 0) begin
      if (m_dn) begin m_addr = m_sp; nsp = m_sp - 1; end
      else begin nsp = m_sp + 1; m_addr = nsp; end
      m_rem--; upd = 1;
    end else if (call || push) begin
      m_addr = m_sp; nsp = m_sp - 1; upd = 1;
      if (call) begin m_rem = RA - 1; m_dn = 1; end
    end else if (ret || pop) begin
      nsp = m_sp + 1; m_addr = nsp; upd = 1;
      if (ret) begin m_rem = RA - 1; m_dn = 0; end
    end
    m_valid = upd;
    if (!upd && io_we) begin
      if (io_hi) nsp[15:8] = io_wdata; else nsp[7:0] = io_wdata;
    end
    if (io_re) m_rd = io_hi ? nsp[15:8] : nsp[7:0];
    if (io_we && !io_hi) begin
      m_mask = 1; m_left = LOCKN;
    end else if (m_mask) begin
      if ((io_we && io_hi) || io_oth) begin m_mask = 0; m_left = 0; end
      else if (retire) begin
        m_left--;
        if (m_left == 0) m_mask = 0;
      end
    end
    m_sp = nsp;
  endtask

  task automatic compare_all();
    chk(sp, m_sp, "R2/R3 sp");
    chk({15'd0, irq_mask}, {15'd0, m_mask}, "R9 mask");
    chk({15'd0, busy}, {15'd0, 1'(m_rem > 0)}, "R4 busy");
    chk({15'd0, mem_valid}, {15'd0, m_valid}, "R4 valid");
    if (m_valid) chk(mem_addr, m_addr, "R5 addr");
    chk({8'd0, io_rdata}, {8'd0, m_rd}, "R8 rdata");
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
    io_we = 0; io_re = 0; push = 0; pop = 0; call = 0; ret = 0; retire = 0; io_oth = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [15:0] base;
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    // R1 reset values
    chk(sp, TOP, "R1 sp");
    chk({15'd0, irq_mask}, 16'd0, "R1 mask");
    chk({15'd0, busy}, 16'd0, "R1 busy");
    chk({15'd0, mem_valid}, 16'd0, "R1 valid");

    // R2 push
    push = 1; tick();
    chk(sp, TOP - 1, "R2 sp"); chk(mem_addr, TOP, "R2 addr");
    // R3 pop
    pop = 1; tick();
    chk(sp, TOP, "R3 sp"); chk(mem_addr, TOP, "R3 addr");

    // R4/R6 call, with R13 push during busy
    call = 1; tick();
    chk(mem_addr, TOP, "R4 byte0"); chk({15'd0, busy}, 16'd1, "R4 busy");
    push = 1; tick();
    chk(mem_addr, TOP - 1, "R4 byte1"); chk(sp, TOP - 2, "R13 push ignored");
    tick();
    chk(sp, TOP - 16'(RA), "R6 call size");
    chk({15'd0, busy}, 16'd0, "R4 busy end");
    // R5 ret
    ret = 1; tick(); chk(mem_addr, sp, "R5 addr");
    tick(); tick();
    chk(sp, TOP, "R5 ret size");

    // R12/R7 high write
    io_we = 1; io_hi = 1; io_wdata = 8'h40; tick();
    chk(sp, 16'h40FF, "R7 high write"); chk({15'd0, irq_mask}, 16'd0, "R12 no lock");
    // R7/R9 low write and lockout length
    io_we = 1; io_hi = 0; io_wdata = 8'h80; tick();
    chk(sp, 16'h4080, "R7 low write"); chk({15'd0, irq_mask}, 16'd1, "R9 set");
    for (int i = 0; i < LOCKN - 1; i++) begin retire = 1; tick(); end
    chk({15'd0, irq_mask}, 16'd1, "R9 still set");
    retire = 1; tick();
    chk({15'd0, irq_mask}, 16'd0, "R9 cleared");
    // R11 restart
    io_we = 1; io_hi = 0; io_wdata = 8'h70; tick();
    retire = 1; tick(); retire = 1; tick();
    io_we = 1; io_hi = 0; io_wdata = 8'h60; tick();
    for (int i = 0; i < LOCKN - 1; i++) begin retire = 1; tick(); end
    chk({15'd0, irq_mask}, 16'd1, "R11 restarted");
    retire = 1; tick();
    chk({15'd0, irq_mask}, 16'd0, "R11 end");
    // R10 early end
    io_we = 1; io_hi = 0; tick();
    io_oth = 1; tick();
    chk({15'd0, irq_mask}, 16'd0, "R10 other write");
    io_we = 1; io_hi = 0; tick();
    io_we = 1; io_hi = 1; io_wdata = 8'h41; tick();
    chk({15'd0, irq_mask}, 16'd0, "R10 high write");

    // R8 read with same-cycle push
    base = sp;
    io_re = 1; io_hi = 0; push = 1; tick();
    chk({8'd0, io_rdata}, {8'd0, 8'(base - 1)}, "R8 read sees step");
    // R7 write dropped on step
    base = sp;
    io_we = 1; io_hi = 0; io_wdata = 8'h11; push = 1; tick();
    chk(sp, base - 1, "R7 write dropped");

    // mixed stimulus against the model
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom_range(0, 15));
      case (r)
        0: push = 1;
        1: pop = 1;
        2: call = 1;
        3: ret = 1;
        4: begin io_we = 1; io_hi = 1'($urandom_range(0, 1)); io_wdata = 8'($urandom); end
        5: begin io_re = 1; io_hi = 1'($urandom_range(0, 1)); end
        6: begin io_re = 1; io_hi = 0; push = 1; end
        7: io_oth = ($urandom_range(0, 3) == 0);
        default: ;
      endcase
      retire = ($urandom_range(0, 1) == 1);
      tick();
    end
    report();
  end

endmodule